// File: doc/BRIEF.md
# Float-to-Normalized Color Packer

This block turns up to four single-precision floating-point channel values into unsigned normalized integers and packs them into one output word. It sits in a vector unit's datapath. The sub-vector length and the source and destination element widths come with the data. From them a legality decoder chooses one of four conversions, or rejects the combination as illegal.

Each channel is clamped to the unit interval and scaled to its field maximum: 255 for 8-bit fields, 31 for 5-bit fields and 63 for 6-bit fields. The scaled value is rounded to the nearest integer, with ties going to the even value. The packed word is registered, so the result appears one cycle after a valid input. Channel reordering is left to a separate swizzle stage.

Top module: `fp_color_pack`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid, out_illegal and out_word are all 0 until the first valid input has been registered.
- R2: out_valid is in_valid delayed by exactly one clock. out_illegal and out_word are loaded only on a cycle with in_valid high, and otherwise hold their values.
- R3: A channel with its sign bit set (negative zero included) converts to 0. So does a NaN (exponent 255, fraction nonzero), and so does any input with exponent 0 (zero and denormals). Positive infinity and any value of 1.0 or more convert to the field maximum.
- R4: A value v in (0,1) converts to v·M rounded to nearest with ties to even, where M is 255, 31 or 63 for an 8-, 5- or 6-bit field. For example, 0.5 gives 128, 16 and 32 respectively, and 2^-9 gives 0 in an 8-bit field.
- R5: Element-width codes are 0=8 bits, 1=16 bits, 2=32 bits, 3=64 bits. With in_vec_mode=0, source code 2 and destination code 0, the result is a scalar conversion: out_word[7:0] holds element 0 and bits 31:8 are 0. In scalar mode the sub-vector length is not examined.
- R6: With in_vec_mode=1, in_subvl=4, source code 2 and destination code 2, element i (in_elems[32i+31:32i]) is converted to 8 bits and placed in out_word[8i+7:8i].
- R7: With in_vec_mode=1, in_subvl=3, source code 2 and destination code 2, elements 0 to 2 fill bytes 0 to 2. out_word[31:24] is 0, and element 3 has no effect.
- R8: With in_vec_mode=1, in_subvl=4, source code 2 and destination code 1, the output is a 5-6-5 pixel. Element 0 (×31) goes to bits 4:0, element 1 (×63) to bits 10:5, and element 2 (×31) to bits 15:11. Bits 31:16 are 0, and element 3 has no effect.
- R9: Every other combination raises out_illegal with out_word equal to 0. This includes any sub-vector length other than 3 or 4 in vector mode, a source code other than 2, and a scalar request whose destination is not 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bundle valid |
| in_vec_mode | input | 1 | 1 = vector mode, 0 = scalar mode |
| in_subvl | input | 3 | Sub-vector length (1 to 4) |
| in_src_ew | input | 2 | Source element width code |
| in_dst_ew | input | 2 | Destination element width code |
| in_elems | input | 128 | Four FP32 elements, element 0 in the low bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_illegal | output | 1 | Combination selects no defined conversion |
| out_word | output | 32 | Packed normalized result |

## Verification
The bench builds the block with its defaults: four lanes of 32-bit floats packed into a 32-bit word. At these values every mode is reachable, including the three-lane form, which needs a lane that is present but unused. The unused fourth element can therefore be loaded with extreme values to show that it has no effect. A real-arithmetic reference scales every channel for all three field widths, so the rounding tie at one half is compared for every scale factor the block uses.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int MAXF_W = 8;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;

  typedef enum logic [2:0] {
    MD_NONE   = 3'd0,
    MD_SCALAR = 3'd1,
    MD_RGB3   = 3'd2,
    MD_RGBA4  = 3'd3,
    MD_565    = 3'd4
  } mode_e;

  // Saturating float to unsigned normalized integer, round to nearest even.
  function automatic logic [MAXF_W-1:0] unorm_conv(input logic [FP_W-1:0] f,
                                                   input int bits);
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic [MAXF_W-1:0] maxv;
    logic [FRAC_W:0]   mant;
    logic [39:0]       prod;
    logic [39:0]       q;
    logic [39:0]       rem;
    logic [39:0]       half;
    logic              up;
    int                sh;
    sgn  = f[FP_W-1];
    ex   = f[FP_W-2:FRAC_W];
    fr   = f[FRAC_W-1:0];
    maxv = MAXF_W'((9'd1 << bits) - 9'd1);
    if (sgn || ex == '0 || (ex == '1 && fr != '0)) return '0;
    if (int'(ex) >= BIAS) return maxv;
    sh = BIAS + FRAC_W - int'(ex);
    if (sh > 33) return '0;
    mant = {1'b1, fr};
    prod = 40'(mant) * 40'(maxv);
    q    = prod >> sh;
    rem  = prod & ((40'd1 << sh) - 40'd1);
    half = 40'd1 << (sh - 1);
    up   = (rem > half) || (rem == half && q[0]);
    return q[MAXF_W-1:0] + {{(MAXF_W-1){1'b0}}, up};
  endfunction
endpackage

// File: rtl/fcp_mode_decode.sv
module fcp_mode_decode
  import fcp_pkg::*;
(
  input  logic       vec_mode,
  input  logic [2:0] subvl,
  input  logic [1:0] src_ew,
  input  logic [1:0] dst_ew,
  output mode_e      mode,
  output logic       illegal
);
  logic src_ok;
  assign src_ok = (src_ew == EW_32);

  always_comb begin
    mode = MD_NONE;
    if (src_ok) begin
      if (!vec_mode) begin
        if (dst_ew == EW_8) mode = MD_SCALAR;
      end else if (subvl == 3'd4 && dst_ew == EW_32) begin
        mode = MD_RGBA4;
      end else if (subvl == 3'd3 && dst_ew == EW_32) begin
        mode = MD_RGB3;
      end else if (subvl == 3'd4 && dst_ew == EW_16) begin
        mode = MD_565;
      end
    end
    illegal = (mode == MD_NONE);
  end

  always_comb begin
    // R9
    src_width_chk: assert (src_ok || illegal);
    // R5
    scalar_only_chk: assert (!(vec_mode && mode == MD_SCALAR));
  end
endmodule

// File: rtl/fcp_chan_conv.sv
module fcp_chan_conv
  import fcp_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic [FP_W-1:0]  f_in,
  output logic [OUT_W-1:0] res,
  output logic             zero_force,
  output logic             sat_hi
);
  localparam logic [OUT_W-1:0] FMAX = {OUT_W{1'b1}};
  logic [MAXF_W-1:0] wide;

  assign zero_force = f_in[FP_W-1] || (f_in[FP_W-2:FRAC_W] == '0) ||
                      (f_in[FP_W-2:FRAC_W] == '1 && f_in[FRAC_W-1:0] != '0);
  assign sat_hi     = !zero_force && (int'(f_in[FP_W-2:FRAC_W]) >= BIAS);
  assign wide       = unorm_conv(f_in, OUT_W);
  assign res        = wide[OUT_W-1:0];

  always_comb begin
    // R3
    zero_force_chk: assert (!zero_force || res == '0);
    // R3
    sat_hi_chk: assert (!sat_hi || res == FMAX);
  end
endmodule

// File: rtl/fcp_pack.sv
module fcp_pack
  import fcp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int U8_W  = 8,
  parameter int OUT_W = LANES * U8_W
) (
  input  mode_e                  mode,
  input  logic [LANES*U8_W-1:0]  u8_lanes,
  input  logic [4:0]             r5,
  input  logic [5:0]             g6,
  input  logic [4:0]             b5,
  output logic [OUT_W-1:0]       word
);
  logic [OUT_W-1:0] w_rgba;
  logic [OUT_W-1:0] w_rgb3;
  logic [OUT_W-1:0] w_scalar;
  logic [OUT_W-1:0] w_565;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_byte
      assign w_rgba[i*U8_W +: U8_W] = u8_lanes[i*U8_W +: U8_W];
      if (i < 3) begin : g_in3
        assign w_rgb3[i*U8_W +: U8_W] = u8_lanes[i*U8_W +: U8_W];
      end else begin : g_out3
        assign w_rgb3[i*U8_W +: U8_W] = '0;
      end
      if (i == 0) begin : g_s
        assign w_scalar[i*U8_W +: U8_W] = u8_lanes[i*U8_W +: U8_W];
      end else begin : g_ns
        assign w_scalar[i*U8_W +: U8_W] = '0;
      end
    end
  endgenerate

  assign w_565 = {{(OUT_W-16){1'b0}}, b5, g6, r5};

  always_comb begin
    case (mode)
      MD_SCALAR: word = w_scalar;
      MD_RGB3:   word = w_rgb3;
      MD_RGBA4:  word = w_rgba;
      MD_565:    word = w_565;
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/fp_color_pack.sv
module fp_color_pack
  import fcp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int U8_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_vec_mode,
  input  logic [2:0]             in_subvl,
  input  logic [1:0]             in_src_ew,
  input  logic [1:0]             in_dst_ew,
  input  logic [LANES*FP_W-1:0]  in_elems,
  output logic                   out_valid,
  output logic                   out_illegal,
  output logic [LANES*U8_W-1:0]  out_word
);
  localparam int OUT_W = LANES * U8_W;

  mode_e              mode_d;
  mode_e              mode_q;
  logic               illegal_d;
  logic [OUT_W-1:0]   u8_lanes;
  logic [LANES-1:0]   lane_zero;
  logic [LANES-1:0]   lane_sat;
  logic [4:0]         r5;
  logic [5:0]         g6;
  logic [4:0]         b5;
  logic [2:0]         z565;
  logic [2:0]         s565;
  logic [OUT_W-1:0]   packed_d;

  fcp_mode_decode u_dec (
    .vec_mode (in_vec_mode),
    .subvl    (in_subvl),
    .src_ew   (in_src_ew),
    .dst_ew   (in_dst_ew),
    .mode     (mode_d),
    .illegal  (illegal_d)
  );

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_u8
      fcp_chan_conv #(.OUT_W(U8_W)) u_conv (
        .f_in       (in_elems[i*FP_W +: FP_W]),
        .res        (u8_lanes[i*U8_W +: U8_W]),
        .zero_force (lane_zero[i]),
        .sat_hi     (lane_sat[i])
      );
    end
  endgenerate

  fcp_chan_conv #(.OUT_W(5)) u_conv_r5 (
    .f_in (in_elems[0 +: FP_W]), .res (r5),
    .zero_force (z565[0]), .sat_hi (s565[0])
  );
  fcp_chan_conv #(.OUT_W(6)) u_conv_g6 (
    .f_in (in_elems[FP_W +: FP_W]), .res (g6),
    .zero_force (z565[1]), .sat_hi (s565[1])
  );
  fcp_chan_conv #(.OUT_W(5)) u_conv_b5 (
    .f_in (in_elems[2*FP_W +: FP_W]), .res (b5),
    .zero_force (z565[2]), .sat_hi (s565[2])
  );

  fcp_pack #(.LANES(LANES), .U8_W(U8_W)) u_pack (
    .mode     (mode_d),
    .u8_lanes (u8_lanes),
    .r5       (r5),
    .g6       (g6),
    .b5       (b5),
    .word     (packed_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_word    <= '0;
      mode_q      <= MD_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= illegal_d;
        out_word    <= illegal_d ? '0 : packed_d;
        mode_q      <= mode_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_word) && $stable(out_illegal)));
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_word == '0);
  // R7
  rgb3_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RGB3 && !out_illegal) |-> out_word[OUT_W-1 -: U8_W] == '0);
  // R8
  pix565_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_565 && !out_illegal) |-> out_word[OUT_W-1:16] == '0);
  // R5
  scalar_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SCALAR && !out_illegal) |-> out_word[OUT_W-1:U8_W] == '0);
endmodule

// File: tb/fp_color_pack_bench.sv
`timescale 1ns/1ps
module fp_color_pack_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_vec_mode = 1'b0;
  logic [2:0]   in_subvl = 3'd0;
  logic [1:0]   in_src_ew = 2'd0;
  logic [1:0]   in_dst_ew = 2'd0;
  logic [127:0] in_elems = '0;
  logic         out_valid;
  logic         out_illegal;
  logic [31:0]  out_word;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] F_ONE  = 32'h3F80_0000;
  localparam logic [31:0] F_HALF = 32'h3F00_0000;
  localparam logic [31:0] F_QTR  = 32'h3E80_0000;
  localparam logic [31:0] F_3Q   = 32'h3F40_0000;
  localparam logic [31:0] F_TWO  = 32'h4000_0000;
  localparam logic [31:0] F_NHLF = 32'hBF00_0000;
  localparam logic [31:0] F_NZ   = 32'h8000_0000;
  localparam logic [31:0] F_INF  = 32'h7F80_0000;
  localparam logic [31:0] F_NAN  = 32'h7FC0_0000;
  localparam logic [31:0] F_DEN  = 32'h0000_0001;
  localparam logic [31:0] F_256  = 32'h3B80_0000;
  localparam logic [31:0] F_512  = 32'h3B00_0000;
  localparam logic [31:0] F_P1   = 32'h3DCC_CCCD;
  localparam logic [31:0] F_P9   = 32'h3F66_6666;
  localparam logic [31:0] F_P3   = 32'h3E99_999A;

  always #4 clk = ~clk;

  fp_color_pack u_fp_color_pack (
    .clk, .rst_n, .in_valid, .in_vec_mode, .in_subvl, .in_src_ew,
    .in_dst_ew, .in_elems, .out_valid, .out_illegal, .out_word
  );

  // Independent reference in real arithmetic.
  function automatic int ref_unorm(logic [31:0] f, int m);
    int  e;
    real v;
    real x;
    real fl;
    int  r;
    e = int'(f[30:23]);
    if (f[31]) return 0;
    if (e == 0) return 0;
    if (e == 255) return (f[22:0] != 0) ? 0 : m;
    v = 1.0 + real'(f[22:0]) / 8388608.0;
    for (int k = 0; k < 127 - e; k++) v = v / 2.0;
    for (int k = 0; k < e - 127; k++) v = v * 2.0;
    if (v >= 1.0) return m;
    x  = v * real'(m);
    fl = $floor(x);
    r  = $rtoi(fl);
    if ((x - fl) > 0.5 || ((x - fl) == 0.5 && (r % 2) == 1)) r = r + 1;
    return r;
  endfunction

  function automatic logic [31:0] ref_rgba(logic [31:0] a, b, c, d);
    return {8'(ref_unorm(d, 255)), 8'(ref_unorm(c, 255)),
            8'(ref_unorm(b, 255)), 8'(ref_unorm(a, 255))};
  endfunction

  function automatic logic [31:0] ref_565(logic [31:0] a, b, c);
    return {16'd0, 5'(ref_unorm(c, 31)), 6'(ref_unorm(b, 63)), 5'(ref_unorm(a, 31))};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(bit vec, logic [2:0] sv, logic [1:0] s, logic [1:0] d,
                       logic [31:0] e0, e1, e2, e3);
    @(negedge clk);
    in_valid    = 1'b1;
    in_vec_mode = vec;
    in_subvl    = sv;
    in_src_ew   = s;
    in_dst_ew   = d;
    in_elems    = {e3, e2, e1, e0};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 illegal in reset", {31'd0, out_illegal}, 32'd0);
    check("R1 word in reset", out_word, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after release", out_word, 32'd0);
  endtask

  task automatic t_scalar();
    issue(1'b0, 3'd1, 2'd2, 2'd0, F_3Q, F_ONE, F_ONE, F_ONE);
    check("R5 scalar 0.75", out_word, 32'(ref_unorm(F_3Q, 255)));
    check("R5 scalar legal", {31'd0, out_illegal}, 32'd0);
    issue(1'b0, 3'd4, 2'd2, 2'd0, F_P1, F_ONE, F_ONE, F_ONE);
    check("R5 scalar subvl ignored", out_word, 32'(ref_unorm(F_P1, 255)));
  endtask

  task automatic t_rgba();
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_QTR, F_HALF, F_3Q, F_ONE);
    check("R6 rgba ramp", out_word, ref_rgba(F_QTR, F_HALF, F_3Q, F_ONE));
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_P1, F_P9, F_P3, F_256);
    check("R6 rgba mixed", out_word, ref_rgba(F_P1, F_P9, F_P3, F_256));
  endtask

  task automatic t_rgb3();
    issue(1'b1, 3'd3, 2'd2, 2'd2, F_ONE, F_QTR, F_HALF, F_INF);
    check("R7 rgb3 elem3 inf", out_word, {8'd0, ref_rgba(F_ONE, F_QTR, F_HALF, 32'd0)});
    issue(1'b1, 3'd3, 2'd2, 2'd2, F_ONE, F_QTR, F_HALF, F_3Q);
    check("R7 rgb3 elem3 ignored", out_word, 32'h0080_40FF);
  endtask

  task automatic t_565();
    issue(1'b1, 3'd4, 2'd2, 2'd1, F_HALF, F_HALF, F_HALF, F_ONE);
    check("R8 565 half", out_word, ref_565(F_HALF, F_HALF, F_HALF));
    issue(1'b1, 3'd4, 2'd2, 2'd1, F_ONE, F_P3, F_NHLF, F_ONE);
    check("R8 565 mixed", out_word, ref_565(F_ONE, F_P3, F_NHLF));
    issue(1'b1, 3'd4, 2'd2, 2'd1, F_ONE, F_P3, F_NHLF, F_NAN);
    check("R8 565 elem3 ignored", out_word, ref_565(F_ONE, F_P3, F_NHLF));
  endtask

  task automatic t_saturate();
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_NZ, F_NAN, F_DEN, F_NHLF);
    check("R3 zero forcing", out_word, 32'd0);
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_INF, F_TWO, F_ONE, 32'd0);
    check("R3 saturate high", out_word, 32'h00FF_FFFF);
  endtask

  task automatic t_round();
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_HALF, F_512, F_256, F_P9);
    check("R4 round bytes", out_word, {8'(ref_unorm(F_P9, 255)), 8'd1, 8'd0, 8'd128});
    issue(1'b1, 3'd4, 2'd2, 2'd1, F_HALF, F_HALF, F_QTR, 32'd0);
    check("R4 round 565 ties", out_word, {16'd0, 5'd8, 6'd32, 5'd16});
  endtask

  task automatic t_illegal();
    issue(1'b1, 3'd4, 2'd2, 2'd2, F_ONE, F_ONE, F_ONE, F_ONE);
    issue(1'b1, 3'd2, 2'd2, 2'd2, F_ONE, F_ONE, F_ONE, F_ONE);
    check("R9 subvl2 flag", {31'd0, out_illegal}, 32'd1);
    check("R9 subvl2 word", out_word, 32'd0);
    issue(1'b1, 3'd4, 2'd3, 2'd2, F_ONE, F_ONE, F_ONE, F_ONE);
    check("R9 src64 flag", {31'd0, out_illegal}, 32'd1);
    issue(1'b0, 3'd1, 2'd2, 2'd2, F_ONE, F_ONE, F_ONE, F_ONE);
    check("R9 scalar dst32", {31'd0, out_illegal}, 32'd1);
    issue(1'b1, 3'd1, 2'd2, 2'd0, F_ONE, F_ONE, F_ONE, F_ONE);
    check("R9 vector subvl1", {31'd0, out_illegal}, 32'd1);
    issue(1'b1, 3'd3, 2'd2, 2'd1, F_ONE, F_ONE, F_ONE, F_ONE);
    check("R9 rgb3 dst16", {31'd0, out_illegal}, 32'd1);
  endtask

  task automatic t_timing();
    @(negedge clk);
    in_valid = 1'b1;
    in_vec_mode = 1'b1; in_subvl = 3'd4; in_src_ew = 2'd2; in_dst_ew = 2'd2;
    in_elems = {F_ONE, F_ONE, F_ONE, F_ONE};
    check("R2 not yet valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid after one cycle", {31'd0, out_valid}, 32'd1);
    check("R2 word with valid", out_word, 32'hFFFF_FFFF);
    in_elems = '0;
    in_subvl = 3'd2;
    @(negedge clk);
    check("R2 valid drops", {31'd0, out_valid}, 32'd0);
    check("R2 word holds", out_word, 32'hFFFF_FFFF);
    check("R2 flag holds", {31'd0, out_illegal}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_scalar();
    t_rgba();
    t_rgb3();
    t_565();
    t_saturate();
    t_round();
    t_illegal();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule